// File: doc/BRIEF.md
# Single-Precision to Bfloat16 Converter

This block narrows one 32-bit IEEE single-precision value to a 16-bit bfloat16 value. It keeps the sign and the 8-bit exponent and cuts the mantissa from 23 bits to 7. Rounding is always round-to-nearest with ties to even. No rounding-mode input exists. No floating-point status is read, and no exception is ever signalled.

The input word is sorted into one of four classes using only its own exponent and mantissa fields. The input fields are sign at bit 31, exponent at bits 30:23 and mantissa at bits 22:0. Each class is handled as follows:
- Zeros and denormals become a zero that keeps the input sign.
- Infinities pass through.
- NaNs come out quiet.
- Normal numbers are rounded by an unsigned integer bias add and then truncated.

When rounding a normal value carries into the exponent, the carry alone produces an infinity of the correct sign. No special-case logic handles this.

A parameter selects whether the result is registered once before the output or leaves the block combinationally. A valid bit travels alongside the data with the same latency, so the block can sit in a pipeline.

The datapath has two named paths:
- The convert path is classify, then round, then select.
- The stage path is the optional output register.

The register has two named states, EMPTY (out_valid low) and HOLDING (out_valid high). The transition to HOLDING happens on a clock edge with in_valid high. The transition to EMPTY happens on a clock edge with in_valid low, or on reset.

Top module: `fp32_to_bf16_cvt`

## Requirements
- R1: An input whose exponent field (bits 30:23) is zero, whether a zero or a denormal, gives an output with bit 15 equal to input bit 31 and bits 14:0 all zero.
- R2: An input with exponent field 0xFF and mantissa field (bits 22:0) zero, an infinity, gives as output input bits 31:16 unchanged; 0x7F800000 gives 0x7F80 and 0xFF800000 gives 0xFF80.
- R3: An input with exponent field 0xFF and a nonzero mantissa, a NaN, gives input bits 31:16 with output bit 6 forced to 1, so a signalling NaN whose payload lies only in bits 15:0 still yields a quiet NaN (0x7F800001 gives 0x7FC0).
- R4: Any other input, a normal number, gives bits 31:16 of the unsigned 32-bit sum of the input, 0x00007FFF and input bit 16.
- R5: Exact halfway cases (input bits 15:0 equal to 0x8000) round to the even kept value in both directions: 0x3F808000 gives 0x3F80 and 0x3F818000 gives 0x3F82.
- R6: A normal input whose rounding carries into the exponent gives the signed infinity: 0x7F7FFFFF gives 0x7F80 and 0xFF7FFFFF gives 0xFF80.
- R7: With the output register enabled (OUT_REG=1, the default), out_valid and bf_out follow in_valid and the converted fp_in exactly one clock later. While rst_n is low (active low), out_valid and bf_out are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| in_valid | input | 1 | Marks fp_in as carrying a value to convert |
| fp_in | input | 32 | Single-precision input word |
| out_valid | output | 1 | Marks bf_out as carrying a converted value |
| bf_out | output | 16 | Bfloat16 result |

## Verification
The converter is driven with hand-picked words from every input class:
- signed zeros and denormals of both signs, including the largest negative denormal
- both infinities
- quiet NaNs, and signalling NaNs whose payload sits either high or only in the low mantissa bits
- normal values just below, exactly at, and just above the halfway point

The denormals tell flushing apart from rounding. The low-payload NaNs tell truncation apart from quieting. The halfway values with an even kept bit and with an odd kept bit tell ties-to-even apart from plain round-half-up. The largest finite values of both signs show whether the carry produces the signed infinity. A pseudo-random sweep of several thousand words, checked against a model built from the class rules, then covers the normal rounding path broadly. Gaps in in_valid show whether the valid bit lines up with the data.

// File: rtl/bf16_cvt_pkg.sv
package bf16_cvt_pkg;
    localparam int FP_W   = 32;
    localparam int BF_W   = 16;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = FP_W - EXP_W - 1;
    localparam int DROP_W = FP_W - BF_W;
    localparam int QUIET_BIT = MAN_W - 1 - DROP_W;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_INF  = 2'd1,
        CLS_NAN  = 2'd2,
        CLS_NORM = 2'd3
    } fp_class_e;
endpackage

// File: rtl/fp32_classifier.sv
module fp32_classifier
    import bf16_cvt_pkg::*;
(
    input  logic [FP_W-1:0] word_i,
    output fp_class_e       cls_o
);
    logic [EXP_W-1:0] exp_field;
    logic [MAN_W-1:0] man_field;
    logic             exp_zero;
    logic             exp_ones;
    logic             man_zero;

    assign exp_field = word_i[FP_W-2 -: EXP_W];
    assign man_field = word_i[MAN_W-1:0];
    assign exp_zero  = (exp_field == '0);
    assign exp_ones  = (exp_field == '1);
    assign man_zero  = (man_field == '0);

    always_comb begin
        if (exp_zero)
            cls_o = CLS_ZERO;
        else if (exp_ones && man_zero)
            cls_o = CLS_INF;
        else if (exp_ones)
            cls_o = CLS_NAN;
        else
            cls_o = CLS_NORM;
    end
endmodule

// File: rtl/fp32_rne_rounder.sv
module fp32_rne_rounder
    import bf16_cvt_pkg::*;
(
    input  logic [FP_W-1:0] word_i,
    output logic [BF_W-1:0] rounded_o
);
    localparam logic [FP_W-1:0] HALF_LESS_ONE = FP_W'((64'd1 << (DROP_W - 1)) - 64'd1);

    logic [FP_W-1:0] bias;
    logic [FP_W-1:0] sum;

    assign bias      = HALF_LESS_ONE + {{(FP_W-1){1'b0}}, word_i[DROP_W]};
    assign sum       = word_i + bias;
    assign rounded_o = sum[FP_W-1:DROP_W];
endmodule

// File: rtl/bf16_result_select.sv
module bf16_result_select
    import bf16_cvt_pkg::*;
(
    input  fp_class_e       cls_i,
    input  logic [FP_W-1:0] word_i,
    input  logic [BF_W-1:0] rounded_i,
    output logic [BF_W-1:0] result_o
);
    logic [BF_W-1:0] upper;

    assign upper = word_i[FP_W-1:DROP_W];

    always_comb begin
        result_o = upper;
        unique case (cls_i)
            CLS_ZERO: result_o = {word_i[FP_W-1], {(BF_W-1){1'b0}}};
            CLS_INF:  result_o = upper;
            CLS_NAN: begin
                result_o            = upper;
                result_o[QUIET_BIT] = 1'b1;
            end
            CLS_NORM: result_o = rounded_i;
            default:  result_o = upper;
        endcase
    end
endmodule

// File: rtl/fp32_to_bf16_cvt.sv
module fp32_to_bf16_cvt
    import bf16_cvt_pkg::*;
#(
    parameter int OUT_REG = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     fp_in,
    output logic            out_valid,
    output logic [15:0]     bf_out
);
    fp_class_e       cls;
    logic [BF_W-1:0] rounded;
    logic [BF_W-1:0] result;

    fp32_classifier u_classify (
        .word_i (fp_in),
        .cls_o  (cls)
    );

    fp32_rne_rounder u_round (
        .word_i    (fp_in),
        .rounded_o (rounded)
    );

    bf16_result_select u_select (
        .cls_i     (cls),
        .word_i    (fp_in),
        .rounded_i (rounded),
        .result_o  (result)
    );

    generate
        if (OUT_REG != 0) begin : g_stage
            typedef enum logic { ST_EMPTY = 1'b0, ST_HOLDING = 1'b1 } stage_e;
            stage_e          state_q;
            logic [BF_W-1:0] data_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    state_q <= ST_EMPTY;
                    data_q  <= '0;
                end else begin
                    state_q <= in_valid ? ST_HOLDING : ST_EMPTY;
                    data_q  <= in_valid ? result : data_q;
                end
            end

            always_comb begin
                unique case (state_q)
                    ST_HOLDING: out_valid = 1'b1;
                    default:    out_valid = 1'b0;
                endcase
                bf_out = data_q;
            end

            p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            p_idle_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            p_data_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (bf_out == $past(result)));
            always_comb begin
                if (!rst_n) begin
                    p_reset_clear_r7: assert (!out_valid && bf_out == '0);
                end
            end
        end else begin : g_comb
            assign out_valid = in_valid;
            assign bf_out    = result;
        end
    endgenerate

    p_zero_flush_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_in[30:23] == 8'h00) |-> (result == {fp_in[31], 15'h0000}));
    p_inf_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_INF) |-> (result == fp_in[31:16]));
    p_nan_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_NAN) |-> (result[14:7] == 8'hFF && result[6] && result[15] == fp_in[31]));
    p_norm_exp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_NORM) |-> (result[14:7] != 8'h00 && result[15] == fp_in[31]));
    p_carry_inf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_NORM && fp_in[30:15] == 16'hFEFF) |-> (result[14:0] == 15'h7F80));
endmodule

// File: tb/fp32_to_bf16_cvt_test.sv
`timescale 1ns/1ps
module fp32_to_bf16_cvt_test;
    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] fp_in;
    logic        out_valid;
    logic [15:0] bf_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [15:0] exp_q[$];
    logic [31:0] in_q[$];
    string       tag_q[$];

    fp32_to_bf16_cvt uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .fp_in     (fp_in),
        .out_valid (out_valid),
        .bf_out    (bf_out)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [15:0] model(input logic [31:0] x);
        logic [31:0] s;
        logic [15:0] r;
        if (x[30:23] == 8'h00) return {x[31], 15'h0000};
        if (x[30:23] == 8'hFF) begin
            r = x[31:16];
            if (x[22:0] != 0) r[6] = 1'b1;
            return r;
        end
        s = x + 32'h0000_7FFF + {31'b0, x[16]};
        return s[31:16];
    endfunction

    function automatic string class_tag(input logic [31:0] x);
        if (x[30:23] == 8'h00) return "R1";
        if (x[30:23] == 8'hFF) return (x[22:0] == 0) ? "R2" : "R3";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, want);
        end
    endtask

    task automatic drive(input logic [31:0] x, input logic [15:0] want, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        fp_in    = x;
        exp_q.push_back(want);
        in_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            fp_in    = 32'hDEAD_BEEF;
        end
    endtask

    // monitor: pops the scoreboard when a result appears
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected out_valid", 32'd1, 32'd0);
                end else begin
                    logic [15:0] w;
                    logic [31:0] src;
                    string       t;
                    w   = exp_q.pop_front();
                    src = in_q.pop_front();
                    t   = tag_q.pop_front();
                    checks++;
                    if (bf_out !== w) begin
                        errors++;
                        $display("FAIL %s in=0x%08h: actual 0x%04h expected 0x%04h", t, src, bf_out, w);
                    end
                end
            end
        end
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        rst_n    = 1'b0;
        in_valid = 1'b1;
        fp_in    = 32'h3F80_0000;
        repeat (3) @(negedge clk);
        check("R7 reset out_valid", {31'b0, out_valid}, 32'd0);
        check("R7 reset bf_out", {16'b0, bf_out}, 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 zeros and denormals
        drive(32'h0000_0000, 16'h0000, "R1 +zero");
        drive(32'h8000_0000, 16'h8000, "R1 -zero");
        drive(32'h0000_0001, 16'h0000, "R1 +denormal");
        drive(32'h807F_FFFF, 16'h8000, "R1 -denormal max");
        drive(32'h8000_8000, 16'h8000, "R1 -denormal tie");
        // R2 infinities
        drive(32'h7F80_0000, 16'h7F80, "R2 +inf");
        drive(32'hFF80_0000, 16'hFF80, "R2 -inf");
        idle(1);
        // R3 NaNs
        drive(32'h7FC0_0000, 16'h7FC0, "R3 qNaN");
        drive(32'h7F80_0001, 16'h7FC0, "R3 sNaN low payload");
        drive(32'hFF80_FFFF, 16'hFFC0, "R3 -sNaN low payload");
        drive(32'h7FA0_0000, 16'h7FE0, "R3 sNaN high payload");
        // R4 normals
        drive(32'h3F80_0000, 16'h3F80, "R4 one");
        drive(32'h3F80_8001, 16'h3F81, "R4 above half");
        drive(32'h3F80_7FFF, 16'h3F80, "R4 below half");
        drive(32'hC049_0FDB, 16'hC049, "R4 -pi");
        // R5 ties to even
        drive(32'h3F80_8000, 16'h3F80, "R5 tie stays even");
        drive(32'h3F81_8000, 16'h3F82, "R5 tie rounds up to even");
        drive(32'hBF81_8000, 16'hBF82, "R5 -tie rounds up to even");
        // R6 carry into exponent
        drive(32'h7F7F_FFFF, 16'h7F80, "R6 +max to inf");
        drive(32'hFF7F_FFFF, 16'hFF80, "R6 -max to inf");
        drive(32'h3F7F_FFFF, 16'h3F80, "R6 carry to next binade");
        idle(3);

        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            drive(lfsr, model(lfsr), class_tag(lfsr));
            if (lfsr[3:0] == 4'h0) idle(1);
        end
        idle(4);
        check("R7 scoreboard drained", exp_q.size(), 32'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule